// File: doc/BRIEF.md
# Audio Frame-to-Master Clock Ratio Speed Detector

This block sits at the clock input of a serial audio port. It counts master-clock cycles across each period of the frame clock, whose rate equals the sample rate. The frame clock is a synchronous integer divisor of the master clock. An optional divide-by-two halves the master clock before any internal logic sees it, the ratio counter included. The block turns the measured ratio into one of four speed codes, or it checks the ratio against the set that a software-chosen speed code allows. It reports the code with a valid flag and an error flag.

A role strap is sampled once, on the first clock edge after reset. It selects slave (low) or master (high). Automatic classification is available only in slave role. In master role the software speed field is always used. The block has no streaming data path. All its pins are plain control and status levels, with no valid/ready handshake and no back-pressure.

The ratio is counted in divided master-clock ticks between consecutive rising frame-clock edges. The frame clock passes through a two-flop synchroniser before edge detection. The first period after reset, and the first period after a saturation, are not measured.

Top module: `aclk_ratio_detect`

## Requirements
- R1: With `div2_en_i` high, the counter advances on every second master-clock cycle, so all ratio sets and the saturation limit apply to half the raw cycle count.
- R2: With automatic mode in effect and no divide, raw ratios classify as follows: 128 and 192 give code 00 (double), 256 and 384 give 01 (single), 512 and 768 give 10 (half), and 1024 and 1536 give 11 (quarter).
- R3: With automatic mode and the divide on, the legal raw ratios double: 256/384 → 00, 512/768 → 01, 1024/1536 → 10, 2048/3072 → 11.
- R4: In manual mode the code equals `speed_sel_i`. The legal divided ratios are: for 00, {128,192,256,384}; for 01, {128..768}; for 10, {256..1536}; for 11, {512..3072}. Each range contains only the values k·128 and k·192 for powers of two k.
- R5: A measured ratio outside the allowed set raises `error_o` and drops `valid_o` one cycle after that period is measured.
- R6: If 4095 counted ticks pass with no frame edge, `error_o` rises and `valid_o` falls.
- R7: `speed_o` updates, and `valid_o` rises, only when two consecutive measured periods give the same legal ratio. A single differing legal period leaves the code and the flags unchanged. A confirmation clears `error_o`.
- R8: `role_master_o` takes the value of `role_strap_i` at the first clock edge after reset and holds it until the next reset.
- R9: In master role the automatic mode is ignored and the manual rules of R4 apply.
- R10: After reset, `speed_o` is 00 and `valid_o` and `error_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| role_strap_i | input | 1 | Role strap: 0 slave, 1 master |
| div2_en_i | input | 1 | Halve the master clock before counting |
| auto_en_i | input | 1 | Request automatic speed classification |
| speed_sel_i | input | 2 | Software speed code used in manual mode |
| frame_clk_i | input | 1 | Frame clock, asynchronous to sampling |
| role_master_o | output | 1 | Latched role, 1 for master |
| speed_o | output | 2 | Speed code: 00 double, 01 single, 10 half, 11 quarter |
| valid_o | output | 1 | Speed code confirmed and current |
| error_o | output | 1 | Illegal ratio or missing frame clock |

## Verification
Saturation and the confirmation of a measured period both drive the valid and error flags. When they meet, saturation must win, and a frame edge must clear the saturated counter before either path fires again. The bench reaches a confirmed mode, then stops the frame clock with the divide on. It checks that valid still holds after about 4400 raw cycles. At that point the halved counter is still short of its limit. The bench checks again after about 8500 raw cycles, where error must be set and valid cleared. The same stop without the divide must flag the error well before 4400 cycles.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
  typedef enum logic [1:0] {
    SPD_DOUBLE  = 2'b00,
    SPD_SINGLE  = 2'b01,
    SPD_HALF    = 2'b10,
    SPD_QUARTER = 2'b11
  } speed_e;
endpackage

// File: rtl/aclk_tick_gen.sv
module aclk_tick_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic div2_i,
  output logic tick_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= 1'b0;
    else if (div2_i) phase_q <= ~phase_q;
    else phase_q <= 1'b0;
  end

  assign tick_o = ~div2_i | phase_q;
endmodule

// File: rtl/aclk_frame_meter.sv
module aclk_frame_meter #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             frame_i,
  output logic             meas_vld_o,
  output logic [CNT_W-1:0] meas_cnt_o,
  output logic             sat_o
);
  localparam logic [CNT_W-1:0] SAT_VAL = {CNT_W{1'b1}};

  logic [2:0]       sync_q;
  logic             rise;
  logic [CNT_W-1:0] cnt_q;
  logic             primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else sync_q <= {sync_q[1:0], frame_i};
  end

  assign rise  = sync_q[1] & ~sync_q[2];
  assign sat_o = (cnt_q == SAT_VAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      primed_q   <= 1'b0;
      meas_vld_o <= 1'b0;
      meas_cnt_o <= '0;
    end else if (rise) begin
      meas_vld_o <= primed_q & ~sat_o;
      meas_cnt_o <= cnt_q + CNT_W'(tick_i);
      cnt_q      <= '0;
      primed_q   <= 1'b1;
    end else begin
      meas_vld_o <= 1'b0;
      if (tick_i && !sat_o) cnt_q <= cnt_q + 1'b1;
      if (sat_o) primed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/aclk_ratio_classify.sv
module aclk_ratio_classify #(
  parameter int CNT_W      = 12,
  parameter int BASE_RATIO = 128,
  parameter int PAIRS      = 5
) (
  input  logic             [CNT_W-1:0] ratio_i,
  input  logic                         auto_i,
  input  logic             [1:0]       sel_i,
  output logic                         legal_o,
  output aclk_pkg::speed_e             code_o
);
  localparam int ODD_RATIO = (BASE_RATIO * 3) / 2;

  logic [PAIRS-1:0] hit;

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    assign hit[k] = (ratio_i == CNT_W'(BASE_RATIO << k)) ||
                    (ratio_i == CNT_W'(ODD_RATIO << k));
  end

  always_comb begin
    int  idx;
    int  lo;
    int  hi;
    logic found;
    found = 1'b0;
    idx   = 0;
    for (int k = 0; k < PAIRS; k++) begin
      if (hit[k]) begin
        found = 1'b1;
        idx   = k;
      end
    end
    lo = (sel_i == 2'd0) ? 0 : int'(sel_i) - 1;
    hi = (sel_i == 2'd0) ? 1 : int'(sel_i) + 1;
    if (auto_i) begin
      legal_o = found && (idx <= 3);
      code_o  = aclk_pkg::speed_e'(2'(idx));
    end else begin
      legal_o = found && (idx >= lo) && (idx <= hi);
      code_o  = aclk_pkg::speed_e'(sel_i);
    end
  end
endmodule

// File: rtl/aclk_mode_tracker.sv
module aclk_mode_tracker #(
  parameter int CNT_W = 12
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         meas_vld_i,
  input  logic             [CNT_W-1:0] meas_cnt_i,
  input  logic                         sat_i,
  input  logic                         legal_i,
  input  aclk_pkg::speed_e             code_i,
  output aclk_pkg::speed_e             speed_o,
  output logic                         valid_o,
  output logic                         error_o
);
  logic [CNT_W-1:0] pend_q;
  logic             pend_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      speed_o   <= aclk_pkg::SPD_DOUBLE;
      valid_o   <= 1'b0;
      error_o   <= 1'b0;
      pend_q    <= '0;
      pend_ok_q <= 1'b0;
    end else if (sat_i) begin
      valid_o   <= 1'b0;
      error_o   <= 1'b1;
      pend_ok_q <= 1'b0;
    end else if (meas_vld_i) begin
      if (!legal_i) begin
        valid_o   <= 1'b0;
        error_o   <= 1'b1;
        pend_ok_q <= 1'b0;
      end else begin
        if (pend_ok_q && (pend_q == meas_cnt_i)) begin
          speed_o <= code_i;
          valid_o <= 1'b1;
          error_o <= 1'b0;
        end
        pend_q    <= meas_cnt_i;
        pend_ok_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/aclk_ratio_detect.sv
module aclk_ratio_detect #(
  parameter int CNT_W      = 12,
  parameter int BASE_RATIO = 128,
  parameter int PAIRS      = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       role_strap_i,
  input  logic       div2_en_i,
  input  logic       auto_en_i,
  input  logic [1:0] speed_sel_i,
  input  logic       frame_clk_i,
  output logic       role_master_o,
  output logic [1:0] speed_o,
  output logic       valid_o,
  output logic       error_o
);
  logic             tick;
  logic             meas_vld;
  logic [CNT_W-1:0] meas_cnt;
  logic             sat;
  logic             legal;
  logic             auto_eff;
  logic             strap_done_q;
  aclk_pkg::speed_e code;
  aclk_pkg::speed_e speed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_done_q  <= 1'b0;
      role_master_o <= 1'b0;
    end else if (!strap_done_q) begin
      strap_done_q  <= 1'b1;
      role_master_o <= role_strap_i;
    end
  end

  assign auto_eff = auto_en_i & ~role_master_o;

  aclk_tick_gen u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div2_i (div2_en_i),
    .tick_o (tick)
  );

  aclk_frame_meter #(.CNT_W(CNT_W)) u_meter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .frame_i    (frame_clk_i),
    .meas_vld_o (meas_vld),
    .meas_cnt_o (meas_cnt),
    .sat_o      (sat)
  );

  aclk_ratio_classify #(
    .CNT_W(CNT_W), .BASE_RATIO(BASE_RATIO), .PAIRS(PAIRS)
  ) u_class (
    .ratio_i (meas_cnt),
    .auto_i  (auto_eff),
    .sel_i   (speed_sel_i),
    .legal_o (legal),
    .code_o  (code)
  );

  aclk_mode_tracker #(.CNT_W(CNT_W)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .meas_vld_i (meas_vld),
    .meas_cnt_i (meas_cnt),
    .sat_i      (sat),
    .legal_i    (legal),
    .code_i     (code),
    .speed_o    (speed),
    .valid_o    (valid_o),
    .error_o    (error_o)
  );

  assign speed_o = speed;
endmodule

// File: rtl/aclk_ratio_detect_chk.sv
module aclk_ratio_detect_chk #(
  parameter int CNT_W = 12
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       frame_clk_i,
  input logic       role_master_o,
  input logic [1:0] speed_o,
  input logic       valid_o,
  input logic       error_o
);
  localparam int LIMIT = 2 * ((1 << CNT_W) - 1) + 16;

  logic [1:0]  cyc_q;
  logic [2:0]  fsync_q;
  int unsigned idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q   <= '0;
      fsync_q <= '0;
      idle_q  <= 0;
    end else begin
      if (cyc_q != 2'd3) cyc_q <= cyc_q + 1'b1;
      fsync_q <= {fsync_q[1:0], frame_clk_i};
      if (fsync_q[1] && !fsync_q[2]) idle_q <= 0;
      else if (idle_q < LIMIT + 4) idle_q <= idle_q + 1;
    end
  end

  // R5
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && error_o));

  // R7
  code_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(speed_o) |-> valid_o);

  // R5
  valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(valid_o) |-> error_o);

  // R8
  role_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2) |-> $stable(role_master_o));

  // R6
  no_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_q > LIMIT) |-> (error_o && !valid_o));
endmodule

bind aclk_ratio_detect aclk_ratio_detect_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .frame_clk_i   (frame_clk_i),
  .role_master_o (role_master_o),
  .speed_o       (speed_o),
  .valid_o       (valid_o),
  .error_o       (error_o)
);

// File: tb/aclk_ratio_detect_tb_top.sv
module aclk_ratio_detect_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap = 1'b0;
  logic       div2 = 1'b0;
  logic       auto_en = 1'b1;
  logic [1:0] sel = 2'd0;
  logic       frame = 1'b0;
  logic       role;
  logic [1:0] speed;
  logic       valid;
  logic       error;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  aclk_ratio_detect dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .role_strap_i  (strap),
    .div2_en_i     (div2),
    .auto_en_i     (auto_en),
    .speed_sel_i   (sel),
    .frame_clk_i   (frame),
    .role_master_o (role),
    .speed_o       (speed),
    .valid_o       (valid),
    .error_o       (error)
  );

  // fields: [22] auto, [21] div2, [20:19] sel, [18:3] raw ratio, [2] err, [1:0] code
  localparam int NV = 30;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1, 1'b0, 2'd0, 16'd128,  1'b0, 2'd0},
    {1'b1, 1'b0, 2'd0, 16'd192,  1'b0, 2'd0},
    {1'b1, 1'b0, 2'd0, 16'd256,  1'b0, 2'd1},
    {1'b1, 1'b0, 2'd0, 16'd384,  1'b0, 2'd1},
    {1'b1, 1'b0, 2'd0, 16'd512,  1'b0, 2'd2},
    {1'b1, 1'b0, 2'd0, 16'd768,  1'b0, 2'd2},
    {1'b1, 1'b0, 2'd0, 16'd1024, 1'b0, 2'd3},
    {1'b1, 1'b0, 2'd0, 16'd1536, 1'b0, 2'd3},
    {1'b1, 1'b1, 2'd0, 16'd256,  1'b0, 2'd0},
    {1'b1, 1'b1, 2'd0, 16'd384,  1'b0, 2'd0},
    {1'b1, 1'b1, 2'd0, 16'd512,  1'b0, 2'd1},
    {1'b1, 1'b1, 2'd0, 16'd768,  1'b0, 2'd1},
    {1'b1, 1'b1, 2'd0, 16'd1024, 1'b0, 2'd2},
    {1'b1, 1'b1, 2'd0, 16'd1536, 1'b0, 2'd2},
    {1'b1, 1'b1, 2'd0, 16'd2048, 1'b0, 2'd3},
    {1'b1, 1'b1, 2'd0, 16'd3072, 1'b0, 2'd3},
    {1'b0, 1'b0, 2'd3, 16'd512,  1'b0, 2'd3},
    {1'b0, 1'b0, 2'd3, 16'd3072, 1'b0, 2'd3},
    {1'b0, 1'b0, 2'd2, 16'd256,  1'b0, 2'd2},
    {1'b0, 1'b0, 2'd2, 16'd1536, 1'b0, 2'd2},
    {1'b0, 1'b0, 2'd1, 16'd128,  1'b0, 2'd1},
    {1'b0, 1'b0, 2'd1, 16'd768,  1'b0, 2'd1},
    {1'b0, 1'b0, 2'd0, 16'd128,  1'b0, 2'd0},
    {1'b0, 1'b0, 2'd0, 16'd384,  1'b0, 2'd0},
    {1'b0, 1'b1, 2'd3, 16'd6144, 1'b0, 2'd3},
    {1'b0, 1'b1, 2'd0, 16'd768,  1'b0, 2'd0},
    {1'b1, 1'b0, 2'd0, 16'd1000, 1'b1, 2'd0},
    {1'b1, 1'b1, 2'd0, 16'd128,  1'b1, 2'd0},
    {1'b0, 1'b0, 2'd0, 16'd512,  1'b1, 2'd0},
    {1'b0, 1'b0, 2'd3, 16'd256,  1'b1, 2'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_frames(input int n, input int raw);
    for (int i = 0; i < n; i++) begin
      frame = 1'b1;
      repeat (raw / 2) @(negedge clk);
      frame = 1'b0;
      repeat (raw / 2) @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 speed", speed, 0);
    chk("R10 valid", valid, 0);
    chk("R10 error", error, 0);
    chk("R8 role slave", role, 0);

    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      string tag;
      v = VEC[i];
      auto_en = v[22];
      div2    = v[21];
      sel     = v[20:19];
      run_frames(4, int'(v[18:3]));
      if (v[2]) tag = "R5";
      else if (!v[22]) tag = "R4";
      else if (v[21]) tag = "R3";
      else tag = "R2";
      chk({tag, " error"}, error, int'(v[2]));
      chk({tag, " valid"}, valid, int'(!v[2]));
      if (!v[2]) chk({tag, " code"}, speed, int'(v[1:0]));
    end

    // R7 single differing legal period does not alter the report
    auto_en = 1'b1; div2 = 1'b0;
    run_frames(4, 256);
    chk("R7 base code", speed, 1);
    run_frames(1, 512);
    run_frames(1, 256);
    chk("R7 glitch code", speed, 1);
    chk("R7 glitch valid", valid, 1);
    chk("R7 glitch error", error, 0);
    run_frames(3, 256);
    chk("R7 after code", speed, 1);

    // R6 saturation without divide
    frame = 1'b0;
    repeat (4200) @(negedge clk);
    chk("R6 error", error, 1);
    chk("R6 valid", valid, 0);

    // R1 with divide the limit doubles
    div2 = 1'b1;
    run_frames(4, 512);
    chk("R1 relock code", speed, 1);
    chk("R1 relock valid", valid, 1);
    repeat (4200) @(negedge clk);
    chk("R1 half-count no error", error, 0);
    chk("R1 half-count valid", valid, 1);
    repeat (4100) @(negedge clk);
    chk("R1 R6 divided sat error", error, 1);
    chk("R1 R6 divided sat valid", valid, 0);

    // R8 R9 master role latched, automatic request ignored
    rst_n = 1'b0;
    strap = 1'b1;
    div2 = 1'b0; auto_en = 1'b1; sel = 2'd3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    strap = 1'b0;
    run_frames(4, 512);
    chk("R8 role master", role, 1);
    chk("R9 manual code", speed, 3);
    chk("R9 manual valid", valid, 1);
    run_frames(4, 128);
    chk("R9 master illegal error", error, 1);
    chk("R8 role held", role, 1);

    finish_run();
  end
endmodule